// File: doc/BRIEF.md
# Key Event Queue with Status Encoding

This block turns a debounced key-state vector (one bit per key, 64 keys from an 8×8 matrix, key number = column × 8 + row) into a queue of up to 16 key events. A key that goes from released to pressed queues a press. A key that goes from pressed to released queues a release, but only while release reporting is enabled. An autorepeat unit can also ask for a repeat event. When several keys change at once, the events enter the queue one per clock, lowest key number first.

The host pops one entry per read. Each read returns a single status byte. Bits 5:0 hold the key number. Bit 6 is the release flag. Bit 7 is the more-data flag. Reserved codes stand for an empty queue, an overflow and a repeat. Because some of these codes share bit patterns with keys 62 and 63, the more-data bit is forced high for those two keys. The block also gives an interrupt unit the entry count, a sticky overflow flag and a one-cycle read strobe. The queue keeps its contents until the host reads them, so a power-saving state elsewhere loses nothing.

Top module: `kq_event_queue`

## Requirements
- R1: After reset, entry_count is 0, overflow is 0, rd_pulse is 0 and rd_data holds 0x3F.
- R2: A key bit going 0→1 queues a press. Reading it returns key number in bits 5:0 and 0 in bit 6, e.g. key 13 alone reads 0x0D.
- R3: A key bit going 1→0 queues a release (bit 6 = 1) only while release_en is 1. With release_en at 0 the release adds no entry.
- R4: Keys that change in the same cycle are queued in ascending key-number order, one per clock. Bit 7 of a read is 1 when at least one further entry remains after the one returned, and 0 otherwise.
- R5: A read of an empty queue, with no overflow pending, returns 0x3F and leaves entry_count at 0.
- R6: An event arriving while the queue holds 16 entries and no entry leaves in that cycle is dropped and sets overflow. The next read returns 0x7F, pops nothing and clears overflow. Later reads return the 16 retained events, oldest first.
- R7: A one-cycle repeat_req queues a repeat event once no key change is waiting. It reads as 0x3E when it is the last entry and 0x7E when more follow.
- R8: Events of key 62 and key 63 always read with bit 7 set: 0xBE/0xFE for a press/release of key 62, 0xBF/0xFF for key 63.
- R9: rd_data changes in the cycle after rd_req is sampled high. rd_pulse is high in exactly that cycle, for every read, including empty and overflow reads.
- R10: When an event arrives in the same cycle as a popping read of a full queue, the event is kept, overflow stays 0 and entry_count stays 16.
- R11: entry_count never exceeds 16 and changes by at most one per clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| key_state | input | 64 | Debounced key levels, 1 = pressed, bit n = key n |
| release_en | input | 1 | Queue release events when 1 |
| repeat_req | input | 1 | One-cycle request to queue a repeat event |
| rd_req | input | 1 | One-cycle host read request |
| rd_data | output | 8 | Status byte of the most recent read |
| rd_pulse | output | 1 | High for one cycle after each read |
| entry_count | output | 5 | Number of queued events, 0 to 16 |
| overflow | output | 1 | Sticky flag: an event was dropped |

## Verification
The bench provokes a push and a pop in the same clock. It fills the queue to 16, then raises a new key press in the very cycle the host read is sampled. Because the slot frees and fills on the same edge, the bench expects no overflow and a count that stays at 16. It then drains the queue and checks that the new key arrives last, with bit 7 clear. The opposite case, a push into a full queue with no read, is judged by the 0x7F read, a non-popping read, and the loss of exactly the newest event.

// File: rtl/kq_pkg.sv
package kq_pkg;

    localparam int KQ_KEY_W = 6;

    localparam logic [7:0] KQ_CODE_EMPTY    = 8'h3F;
    localparam logic [7:0] KQ_CODE_OVERFLOW = 8'h7F;
    localparam logic [5:0] KQ_CODE_REPEAT   = 6'h3E;
    localparam logic [5:0] KQ_KEY_AMBIG_LO  = 6'd62;

    typedef struct packed {
        logic                rel;
        logic                rep;
        logic [KQ_KEY_W-1:0] key;
    } kq_entry_t;

    localparam int KQ_ENTRY_W = $bits(kq_entry_t);

endpackage

// File: rtl/kq_first_change.sv
module kq_first_change #(
    parameter int N   = 64,
    parameter int IW  = $clog2(N)
) (
    input  logic [N-1:0]  diff,
    output logic          found,
    output logic [IW-1:0] idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (diff[i]) begin
                found = 1'b1;
                idx   = IW'(i);
            end
        end
    end
endmodule

// File: rtl/kq_ring.sv
module kq_ring #(
    parameter int DEPTH = 16,
    parameter int W     = 8,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [W-1:0]  push_data,
    input  logic          pop,
    output logic [W-1:0]  head_data,
    output logic [CW-1:0] count
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [PW-1:0]           head;
        logic [PW-1:0]           tail;
        logic [CW-1:0]           count;
    } ring_t;

    ring_t st_d, st_q;

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
    endfunction

    always_comb begin
        st_d = st_q;
        if (push) begin
            st_d.mem[st_q.tail] = push_data;
            st_d.tail           = bump(st_q.tail);
        end
        if (pop) begin
            st_d.head = bump(st_q.head);
        end
        case ({push, pop})
            2'b10:   st_d.count = st_q.count + CW'(1);
            2'b01:   st_d.count = st_q.count - CW'(1);
            default: st_d.count = st_q.count;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign head_data = st_q.mem[st_q.head];
    assign count     = st_q.count;
endmodule

// File: rtl/kq_status_fmt.sv
module kq_status_fmt
    import kq_pkg::*;
(
    input  kq_entry_t  entry,
    input  logic       more,
    output logic [7:0] status
);
    always_comb begin
        if (entry.rep) begin
            status = {1'b0, more, KQ_CODE_REPEAT};
        end else if (entry.key >= KQ_KEY_AMBIG_LO) begin
            status = {1'b1, entry.rel, entry.key};
        end else begin
            status = {more, entry.rel, entry.key};
        end
    end
endmodule

// File: rtl/kq_event_queue.sv
module kq_event_queue
    import kq_pkg::*;
#(
    parameter int KEYS  = 64,
    parameter int DEPTH = 16,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [KEYS-1:0] key_state,
    input  logic            release_en,
    input  logic            repeat_req,
    input  logic            rd_req,
    output logic [7:0]      rd_data,
    output logic            rd_pulse,
    output logic [CW-1:0]   entry_count,
    output logic            overflow
);
    localparam int IW = $clog2(KEYS);

    typedef struct packed {
        logic [KEYS-1:0] seen;
        logic            ovf;
        logic            rep_pend;
        logic [7:0]      rd_byte;
        logic            rd_pulse;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [KEYS-1:0] diff;
    logic            chg_found;
    logic [IW-1:0]   chg_idx;
    logic            want_push;
    logic            push;
    logic            pop;
    logic            q_full;
    logic            q_empty;
    kq_entry_t       new_entry;
    kq_entry_t       head_entry;
    logic [7:0]      head_status;
    logic [CW-1:0]   count;

    assign diff = key_state ^ ctl_q.seen;

    kq_first_change #(.N(KEYS), .IW(IW)) u_pick (
        .diff  (diff),
        .found (chg_found),
        .idx   (chg_idx)
    );

    kq_ring #(.DEPTH(DEPTH), .W(KQ_ENTRY_W), .CW(CW)) u_ring (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .push_data (new_entry),
        .pop       (pop),
        .head_data (head_entry),
        .count     (count)
    );

    kq_status_fmt u_fmt (
        .entry  (head_entry),
        .more   (count > CW'(1)),
        .status (head_status)
    );

    assign q_full  = (count == CW'(DEPTH));
    assign q_empty = (count == '0);
    assign pop     = rd_req && !ctl_q.ovf && !q_empty;

    always_comb begin
        ctl_d     = ctl_q;
        want_push = 1'b0;
        new_entry = '0;

        if (chg_found) begin
            ctl_d.seen[chg_idx] = key_state[chg_idx];
            want_push           = key_state[chg_idx] || release_en;
            new_entry.rel       = !key_state[chg_idx];
            new_entry.key       = KQ_KEY_W'(chg_idx);
            ctl_d.rep_pend      = ctl_q.rep_pend || repeat_req;
        end else if (ctl_q.rep_pend || repeat_req) begin
            want_push      = 1'b1;
            new_entry.rep  = 1'b1;
            new_entry.key  = KQ_CODE_REPEAT;
            ctl_d.rep_pend = 1'b0;
        end

        push = want_push && (!q_full || pop);

        if (rd_req && ctl_q.ovf) begin
            ctl_d.ovf = 1'b0;
        end
        if (want_push && !push) begin
            ctl_d.ovf = 1'b1;
        end

        ctl_d.rd_pulse = rd_req;
        if (rd_req) begin
            if (ctl_q.ovf) begin
                ctl_d.rd_byte = KQ_CODE_OVERFLOW;
            end else if (q_empty) begin
                ctl_d.rd_byte = KQ_CODE_EMPTY;
            end else begin
                ctl_d.rd_byte = head_status;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q         <= '0;
            ctl_q.rd_byte <= KQ_CODE_EMPTY;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign rd_data     = ctl_q.rd_byte;
    assign rd_pulse    = ctl_q.rd_pulse;
    assign entry_count = count;
    assign overflow    = ctl_q.ovf;
endmodule

// File: rtl/kq_event_queue_chk.sv
module kq_event_queue_chk #(
    parameter int DEPTH = 16,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          rd_req,
    input logic [7:0]    rd_data,
    input logic          rd_pulse,
    input logic [CW-1:0] entry_count,
    input logic          overflow
);
    a_r11_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        entry_count <= CW'(DEPTH));

    a_r11_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        (entry_count == $past(entry_count)) ||
        (entry_count == $past(entry_count) + CW'(1)) ||
        (entry_count == $past(entry_count) - CW'(1)));

    a_r9_pulse_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> rd_pulse);

    a_r9_no_pulse_without_read: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_req |=> !rd_pulse);

    a_r5_empty_code: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !overflow && entry_count == '0) |=> (rd_data == 8'h3F));

    a_r6_overflow_code: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && overflow) |=> (rd_data == 8'h7F));

    a_r6_overflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (overflow && !rd_req) |=> overflow);

    a_r2_nonempty_not_empty_code: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !overflow && entry_count != '0) |=> (rd_data != 8'h3F));
endmodule

bind kq_event_queue kq_event_queue_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .rd_req      (rd_req),
    .rd_data     (rd_data),
    .rd_pulse    (rd_pulse),
    .entry_count (entry_count),
    .overflow    (overflow)
);

// File: tb/kq_event_queue_bench.sv
module kq_event_queue_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] key_state = '0;
    logic        release_en = 1'b0;
    logic        repeat_req = 1'b0;
    logic        rd_req = 1'b0;
    logic [7:0]  rd_data;
    logic        rd_pulse;
    logic [4:0]  entry_count;
    logic        overflow;

    int n_chk  = 0;
    int n_fail = 0;
    bit ended  = 0;

    always #4 clk = ~clk;

    kq_event_queue u_kq_event_queue (
        .clk         (clk),
        .rst_n       (rst_n),
        .key_state   (key_state),
        .release_en  (release_en),
        .repeat_req  (repeat_req),
        .rd_req      (rd_req),
        .rd_data     (rd_data),
        .rd_pulse    (rd_pulse),
        .entry_count (entry_count),
        .overflow    (overflow)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic do_read(input string req, input int exp);
        @(negedge clk);
        rd_req = 1'b1;
        @(negedge clk);
        rd_req = 1'b0;
        chk(req, rd_data, exp);
        chk("R9 pulse", rd_pulse, 1);
    endtask

    task automatic t_reset();
        chk("R1 count", entry_count, 0);
        chk("R1 overflow", overflow, 0);
        chk("R1 rd_data", rd_data, 8'h3F);
        chk("R1 pulse", rd_pulse, 0);
    endtask

    task automatic t_empty();
        do_read("R5 empty read", 8'h3F);
        chk("R5 count", entry_count, 0);
        @(negedge clk);
        chk("R9 pulse one cycle", rd_pulse, 0);
    endtask

    task automatic t_press_release();
        key_state[13] = 1'b1;
        wait_cyc(3);
        chk("R2 count", entry_count, 1);
        do_read("R2 press key13", 8'h0D);
        release_en = 1'b1;
        key_state[13] = 1'b0;
        wait_cyc(3);
        do_read("R3 release key13", 8'h4D);
        release_en = 1'b0;
        key_state[20] = 1'b1;
        wait_cyc(3);
        key_state[20] = 1'b0;
        wait_cyc(3);
        chk("R3 no release when disabled", entry_count, 1);
        do_read("R3 press key20", 8'h14);
        do_read("R3 nothing left", 8'h3F);
    endtask

    task automatic t_multi();
        release_en = 1'b1;
        key_state[40] = 1'b1;
        key_state[3]  = 1'b1;
        key_state[17] = 1'b1;
        wait_cyc(5);
        chk("R4 count", entry_count, 3);
        do_read("R4 first key3", 8'h83);
        do_read("R4 second key17", 8'h91);
        do_read("R4 last key40", 8'h28);
        key_state[40] = 1'b0;
        key_state[3]  = 1'b0;
        key_state[17] = 1'b0;
        wait_cyc(5);
        do_read("R4 rel key3", 8'hC3);
        do_read("R4 rel key17", 8'hD1);
        do_read("R4 rel key40", 8'h68);
        release_en = 1'b0;
    endtask

    task automatic t_repeat();
        @(negedge clk);
        repeat_req = 1'b1;
        @(negedge clk);
        repeat_req = 1'b0;
        wait_cyc(2);
        chk("R7 count", entry_count, 1);
        do_read("R7 repeat last", 8'h3E);
        @(negedge clk);
        repeat_req = 1'b1;
        @(negedge clk);
        repeat_req = 1'b0;
        key_state[7] = 1'b1;
        wait_cyc(3);
        do_read("R7 repeat more", 8'h7E);
        do_read("R7 key7 after repeat", 8'h07);
        key_state[7] = 1'b0;
        wait_cyc(3);
    endtask

    task automatic t_ambig();
        release_en = 1'b1;
        key_state[62] = 1'b1;
        wait_cyc(3);
        do_read("R8 press key62", 8'hBE);
        do_read("R8 then empty", 8'h3F);
        key_state[62] = 1'b0;
        wait_cyc(3);
        do_read("R8 release key62", 8'hFE);
        key_state[63] = 1'b1;
        wait_cyc(3);
        do_read("R8 press key63", 8'hBF);
        key_state[63] = 1'b0;
        wait_cyc(3);
        do_read("R8 release key63", 8'hFF);
        release_en = 1'b0;
    endtask

    task automatic t_overflow();
        for (int k = 0; k <= 16; k++) key_state[k] = 1'b1;
        wait_cyc(20);
        chk("R6 count full", entry_count, 16);
        chk("R6 overflow set", overflow, 1);
        do_read("R6 overflow code", 8'h7F);
        chk("R6 no pop", entry_count, 16);
        chk("R6 overflow cleared", overflow, 0);
        for (int k = 0; k < 16; k++) begin
            do_read("R6 retained", (k == 15) ? k : (8'h80 | k));
        end
        do_read("R6 newest lost", 8'h3F);
        for (int k = 0; k <= 16; k++) key_state[k] = 1'b0;
        wait_cyc(20);
        chk("R11 drained", entry_count, 0);
    endtask

    task automatic t_same_cycle();
        for (int k = 0; k < 16; k++) key_state[k] = 1'b1;
        wait_cyc(19);
        chk("R10 full before", entry_count, 16);
        @(negedge clk);
        key_state[20] = 1'b1;
        rd_req = 1'b1;
        @(negedge clk);
        rd_req = 1'b0;
        chk("R10 popped head", rd_data, 8'h80);
        chk("R10 count kept", entry_count, 16);
        chk("R10 no overflow", overflow, 0);
        for (int k = 1; k < 16; k++) begin
            do_read("R10 drain", 8'h80 | k);
        end
        do_read("R10 new key last", 8'h14);
        chk("R11 empty", entry_count, 0);
    endtask

    task automatic finish_all();
        if (!ended) begin
            ended = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        wait_cyc(3);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_empty();
        t_press_release();
        t_multi();
        t_repeat();
        t_ambig();
        t_overflow();
        t_same_cycle();
        finish_all();
    end

    initial begin
        for (int i = 0; i < 100000; i++) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_all();
    end
endmodule